// File: doc/BRIEF.md
# Asynchronous Static Memory Bus Controller

This block turns single-word read and write requests from a synchronous host into timed cycles on an asynchronous SRAM/NOR-style bus. Address and data travel on separate wires. Each access opens with a programmable address-setup phase and follows it with a data phase. Chip select is held low through both phases. After each access, chip select stays high for a programmable turnaround gap before the next access can start.

Reads always take their timing from the primary set. A write takes its timing from a second, independent set when extended mode is enabled, and from the primary set otherwise. Write data phases last one cycle longer than the programmed length. Read data phases last exactly the programmed length, with a minimum of one cycle. The block drives the data bus only during a write data phase.

The host holds `host_req` and its operands until `host_ack` is seen. Requests are accepted only when the controller is idle and the bank enable is set. Each accepted access ends with a one-cycle `host_done`. For reads, the captured word is presented on `host_rdata` in that same cycle.

Top module: `async_sram_ctrl`

## Requirements
- R1: While reset is asserted and afterwards until a request is accepted, `mem_cs_n`, `mem_oe_n` and `mem_we_n` are 1, `mem_dq_oe` is 0 and `host_done` is 0.
- R2: Following acceptance, chip select is low with both strobes high for exactly the selected setup count of cycles; a setup count of 0 skips this phase.
- R3: A read data phase holds `mem_oe_n` low for exactly max(read length, 1) cycles; `mem_we_n` stays high and `mem_dq_oe` stays 0 for the whole read.
- R4: A write data phase holds `mem_we_n` low for exactly length+1 cycles, with `mem_dq_oe` = 1 and `mem_dq_out` equal to the accepted write word throughout; `mem_oe_n` stays high for the whole write.
- R5: `mem_dq_in` is captured on the last read data cycle and shown on `host_rdata` in the single cycle where `host_done` is 1; `host_done` is never high for two consecutive cycles, and each access gives one such pulse.
- R6: Between two accesses, chip select is high for gap+1 cycles when the next request is already waiting, where gap is the turnaround value of the earlier access.
- R7: With `ext_en` = 1 at acceptance, a write uses `wr_setup`, `wr_dlen` and `wr_gap`; reads, and writes accepted with `ext_en` = 0, use `rd_setup`, `rd_dlen` and `rd_gap`.
- R8: While `bank_en` = 0, no request is accepted and chip select stays high; a request held meanwhile is served once `bank_en` returns to 1.
- R9: `mem_addr` equals the accepted `host_addr` and stays stable for as long as chip select is low.
- R10: `host_ack` is 1 for exactly one cycle per access, only while the controller is idle, and accesses run one at a time in request order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bank_en | input | 1 | Allows requests to be accepted |
| ext_en | input | 1 | Writes take the separate write timing set |
| rd_setup | input | 4 | Primary address-setup cycles |
| rd_dlen | input | 8 | Primary data-phase length |
| rd_gap | input | 4 | Primary turnaround gap |
| wr_setup | input | 4 | Write-set address-setup cycles |
| wr_dlen | input | 8 | Write-set data-phase length |
| wr_gap | input | 4 | Write-set turnaround gap |
| host_req | input | 1 | Request pending, held until acknowledged |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 16 | Word address |
| host_wdata | input | 16 | Write word |
| host_ack | output | 1 | Request accepted this cycle |
| host_rdata | output | 16 | Read word, valid with `host_done` |
| host_done | output | 1 | One-cycle completion pulse |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_addr | output | 16 | Memory address bus |
| mem_dq_out | output | 16 | Data driven towards memory |
| mem_dq_in | input | 16 | Data returned by memory |
| mem_dq_oe | output | 1 | Data bus drive enable |

## Verification
The embedded properties check, on every cycle, that the two strobes are never low together and that the bus is never driven outside a write strobe. They also check that the address holds while chip select is low, that the completion pulse lasts one cycle, and that chip select cannot fall while the bank is disabled. The exact lengths of the setup, data and turnaround phases depend on which timing set was picked and on the off-by-one rules for the two directions. Only the bench scenarios show these, by counting strobe cycles at the pins against its own expected values. Write and read-back data integrity through a memory model is likewise shown only by scenario.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

  typedef enum logic [1:0] {
    SBC_IDLE  = 2'd0,
    SBC_SETUP = 2'd1,
    SBC_DATA  = 2'd2,
    SBC_GAP   = 2'd3
  } sbc_phase_e;

  function automatic int unsigned wmax(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sbc_timing_sel.sv
module sbc_timing_sel #(
  parameter int SET_W = 4,
  parameter int DAT_W = 8,
  parameter int GAP_W = 4,
  parameter int CNT_W = DAT_W + 1
) (
  input  logic             req_we,
  input  logic             ext_en,
  input  logic [SET_W-1:0] rd_setup,
  input  logic [DAT_W-1:0] rd_dlen,
  input  logic [GAP_W-1:0] rd_gap,
  input  logic [SET_W-1:0] wr_setup,
  input  logic [DAT_W-1:0] wr_dlen,
  input  logic [GAP_W-1:0] wr_gap,
  output logic [SET_W-1:0] sel_setup,
  output logic [CNT_W-1:0] sel_dcnt,
  output logic [GAP_W-1:0] sel_gap
);

  logic             use_wr;
  logic [DAT_W-1:0] sel_dlen;

  always_comb begin
    use_wr    = req_we & ext_en;
    sel_setup = use_wr ? wr_setup : rd_setup;
    sel_dlen  = use_wr ? wr_dlen  : rd_dlen;
    sel_gap   = use_wr ? wr_gap   : rd_gap;
    if (req_we) begin
      sel_dcnt = CNT_W'(sel_dlen) + CNT_W'(1);
    end else if (sel_dlen == '0) begin
      sel_dcnt = CNT_W'(1);
    end else begin
      sel_dcnt = CNT_W'(sel_dlen);
    end
  end

endmodule

// File: rtl/sbc_phase_fsm.sv
module sbc_phase_fsm
  import sbc_pkg::*;
#(
  parameter int SET_W = 4,
  parameter int GAP_W = 4,
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [SET_W-1:0] ld_setup,
  input  logic [CNT_W-1:0] ld_dcnt,
  input  logic [GAP_W-1:0] ld_gap,
  output sbc_phase_e       phase,
  output logic             last_data,
  output logic             idle
);

  localparam int CW = int'(wmax(CNT_W, wmax(SET_W, GAP_W)));

  sbc_phase_e       phase_q, phase_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [CNT_W-1:0] dcnt_q;
  logic [GAP_W-1:0] gap_q;
  logic             cnt_zero;

  always_comb begin
    phase_d  = phase_q;
    cnt_d    = cnt_q;
    cnt_zero = (cnt_q == '0);
    case (phase_q)
      SBC_IDLE: begin
        if (start) begin
          if (ld_setup != '0) begin
            phase_d = SBC_SETUP;
            cnt_d   = CW'(ld_setup) - CW'(1);
          end else begin
            phase_d = SBC_DATA;
            cnt_d   = CW'(ld_dcnt) - CW'(1);
          end
        end
      end
      SBC_SETUP: begin
        if (cnt_zero) begin
          phase_d = SBC_DATA;
          cnt_d   = CW'(dcnt_q) - CW'(1);
        end else begin
          cnt_d = cnt_q - CW'(1);
        end
      end
      SBC_DATA: begin
        if (cnt_zero) begin
          if (gap_q != '0) begin
            phase_d = SBC_GAP;
            cnt_d   = CW'(gap_q) - CW'(1);
          end else begin
            phase_d = SBC_IDLE;
          end
        end else begin
          cnt_d = cnt_q - CW'(1);
        end
      end
      default: begin
        if (cnt_zero) begin
          phase_d = SBC_IDLE;
        end else begin
          cnt_d = cnt_q - CW'(1);
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= SBC_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcnt_q <= '0;
      gap_q  <= '0;
    end else if (start) begin
      dcnt_q <= ld_dcnt;
      gap_q  <= ld_gap;
    end
  end

  assign phase     = phase_q;
  assign idle      = (phase_q == SBC_IDLE);
  assign last_data = (phase_q == SBC_DATA) && (cnt_q == '0);

  // R10
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (phase_q == SBC_IDLE));

  // R3
  data_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == SBC_DATA) |-> (cnt_q < CW'(dcnt_q)));

  // R6
  gap_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == SBC_GAP) |-> (cnt_q < CW'(gap_q)));

  // R2
  setup_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == SBC_SETUP) |=> (phase_q == SBC_SETUP) || (phase_q == SBC_DATA));

endmodule

// File: rtl/sbc_datapath.sv
module sbc_datapath #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              last_data,
  input  logic [DATA_W-1:0] mem_din,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic              we_q,
  output logic [DATA_W-1:0] rdata_q,
  output logic              done_q
);

  logic              rd_sample;
  logic [DATA_W-1:0] rdata_d;
  logic              done_d;

  always_comb begin
    rd_sample = last_data & ~we_q;
    rdata_d   = rd_sample ? mem_din : rdata_q;
    done_d    = last_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      we_q    <= 1'b0;
    end else if (capture) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      we_q    <= req_we;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      rdata_q <= rdata_d;
      done_q  <= done_d;
    end
  end

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R5
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_q |=> (done_q || $stable(rdata_q)));

endmodule

// File: rtl/async_sram_ctrl.sv
module async_sram_ctrl
  import sbc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int SET_W  = 4,
  parameter int DLEN_W = 8,
  parameter int GAP_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bank_en,
  input  logic              ext_en,
  input  logic [SET_W-1:0]  rd_setup,
  input  logic [DLEN_W-1:0] rd_dlen,
  input  logic [GAP_W-1:0]  rd_gap,
  input  logic [SET_W-1:0]  wr_setup,
  input  logic [DLEN_W-1:0] wr_dlen,
  input  logic [GAP_W-1:0]  wr_gap,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              host_ack,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_done,
  output logic              mem_cs_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic              mem_dq_oe
);

  localparam int CNT_W = DLEN_W + 1;

  logic [SET_W-1:0] sel_setup;
  logic [CNT_W-1:0] sel_dcnt;
  logic [GAP_W-1:0] sel_gap;
  sbc_phase_e       phase;
  logic             last_data;
  logic             idle;
  logic             accept;
  logic             we_q;
  logic             in_access;
  logic             in_data;

  assign accept = idle & host_req & bank_en;

  sbc_timing_sel #(
    .SET_W (SET_W),
    .DAT_W (DLEN_W),
    .GAP_W (GAP_W),
    .CNT_W (CNT_W)
  ) u_timing_sel (
    .req_we    (host_we),
    .ext_en    (ext_en),
    .rd_setup  (rd_setup),
    .rd_dlen   (rd_dlen),
    .rd_gap    (rd_gap),
    .wr_setup  (wr_setup),
    .wr_dlen   (wr_dlen),
    .wr_gap    (wr_gap),
    .sel_setup (sel_setup),
    .sel_dcnt  (sel_dcnt),
    .sel_gap   (sel_gap)
  );

  sbc_phase_fsm #(
    .SET_W (SET_W),
    .GAP_W (GAP_W),
    .CNT_W (CNT_W)
  ) u_phase_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept),
    .ld_setup  (sel_setup),
    .ld_dcnt   (sel_dcnt),
    .ld_gap    (sel_gap),
    .phase     (phase),
    .last_data (last_data),
    .idle      (idle)
  );

  sbc_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_datapath (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (accept),
    .req_we    (host_we),
    .req_addr  (host_addr),
    .req_wdata (host_wdata),
    .last_data (last_data),
    .mem_din   (mem_dq_in),
    .addr_q    (mem_addr),
    .wdata_q   (mem_dq_out),
    .we_q      (we_q),
    .rdata_q   (host_rdata),
    .done_q    (host_done)
  );

  always_comb begin
    in_access = (phase == SBC_SETUP) || (phase == SBC_DATA);
    in_data   = (phase == SBC_DATA);
    mem_cs_n  = ~in_access;
    mem_oe_n  = ~(in_data & ~we_q);
    mem_we_n  = ~(in_data & we_q);
    mem_dq_oe = in_data & we_q;
    host_ack  = accept;
  end

  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));

  // R4
  dq_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (!mem_we_n && !mem_cs_n));

  // R1
  cs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cs_n |-> (mem_oe_n && mem_we_n && !mem_dq_oe));

  // R9
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cs_n |=> (mem_cs_n || $stable(mem_addr)));

  // R8
  bank_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bank_en && mem_cs_n) |=> mem_cs_n);

endmodule

// File: tb/test_async_sram_ctrl.sv
`timescale 1ns/1ps
module test_async_sram_ctrl;

  logic        clk;
  logic        rst_n;
  logic        bank_en, ext_en;
  logic [3:0]  rd_setup, wr_setup, rd_gap, wr_gap;
  logic [7:0]  rd_dlen, wr_dlen;
  logic        host_req, host_we;
  logic [15:0] host_addr, host_wdata;
  logic        host_ack, host_done;
  logic [15:0] host_rdata;
  logic        mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [15:0] mem_addr, mem_dq_out, mem_dq_in;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  int prev_gap = 0;
  logic [15:0] bmem   [256];
  logic [15:0] shadow [256];
  logic        done_prev = 1'b0;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  async_sram_ctrl i_async_sram_ctrl (
    .clk(clk), .rst_n(rst_n), .bank_en(bank_en), .ext_en(ext_en),
    .rd_setup(rd_setup), .rd_dlen(rd_dlen), .rd_gap(rd_gap),
    .wr_setup(wr_setup), .wr_dlen(wr_dlen), .wr_gap(wr_gap),
    .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_ack(host_ack), .host_rdata(host_rdata),
    .host_done(host_done), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
    .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe)
  );

  // memory model
  assign mem_dq_in = !mem_oe_n ? bmem[mem_addr[7:0]] : 16'h5A5A;
  always @(posedge clk) begin
    if (!mem_we_n && mem_dq_oe) bmem[mem_addr[7:0]] <= mem_dq_out;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // R5: done never two cycles in a row
  always @(negedge clk) begin
    if (rst_n && done_prev && host_done) begin
      n_bad++;
      $display("FAIL R5 done pulse act=2 exp=1");
    end
    done_prev <= host_done;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog act=%0d exp=0", cyc);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  function automatic int e_setup(bit we);
    return (we && ext_en) ? int'(wr_setup) : int'(rd_setup);
  endfunction
  function automatic int e_data(bit we);
    if (we) return (ext_en ? int'(wr_dlen) : int'(rd_dlen)) + 1;
    return (rd_dlen == 0) ? 1 : int'(rd_dlen);
  endfunction
  function automatic int e_gap(bit we);
    return ((we && ext_en) ? int'(wr_gap) : int'(rd_gap)) + 1;
  endfunction

  task automatic access(input bit we, input logic [15:0] a, input logic [15:0] d,
                        input bit gap_chk);
    int hi, sc, dc, guard, bad_str, bad_addr, bad_wd, acks, es, ed, eg;
    string dtag;
    es = e_setup(we); ed = e_data(we); eg = e_gap(we);
    dtag = we ? (ext_en ? "R7 write-set data" : "R4 write data") : "R3 read data";
    host_we = we; host_addr = a; host_wdata = d; host_req = 1'b1;
    hi = 1; guard = 0; acks = 0;
    #1;
    if (host_ack) acks++;
    @(negedge clk);
    while (mem_cs_n && guard < 5000) begin
      hi++; guard++;
      if (host_ack) acks++;
      @(negedge clk);
    end
    host_req = 1'b0;
    sc = 0; dc = 0; bad_str = 0; bad_addr = 0; bad_wd = 0;
    while (!host_done && guard < 5000) begin
      guard++;
      if (host_ack) acks++;
      if (mem_cs_n) bad_str++;
      else begin
        if (mem_addr !== a) bad_addr++;
        if (we) begin
          if (!mem_oe_n) bad_str++;
          if (!mem_we_n) begin
            dc++;
            if (!mem_dq_oe || mem_dq_out !== d) bad_wd++;
          end else begin
            sc++;
            if (mem_dq_oe || dc > 0) bad_str++;
          end
        end else begin
          if (!mem_we_n || mem_dq_oe) bad_str++;
          if (!mem_oe_n) dc++;
          else begin
            sc++;
            if (dc > 0) bad_str++;
          end
        end
      end
      @(negedge clk);
    end
    chk(sc == es, we && ext_en ? "R7 write-set setup" : "R2 setup", sc, es);
    chk(dc == ed, dtag, dc, ed);
    chk(bad_str == 0, we ? "R4 strobes" : "R3 strobes", bad_str, 0);
    chk(bad_addr == 0, "R9 address", bad_addr, 0);
    chk(acks == 1, "R10 ack count", acks, 1);
    if (we) begin
      chk(bad_wd == 0, "R4 write word", bad_wd, 0);
      shadow[a[7:0]] = d;
    end else begin
      chk(host_rdata === shadow[a[7:0]], "R5 read word", int'(host_rdata),
          int'(shadow[a[7:0]]));
    end
    if (gap_chk) chk(hi == prev_gap, "R6 gap", hi, prev_gap);
    prev_gap = eg;
  endtask

  initial begin
    int idle_bad;
    void'($urandom(32'd5511));
    for (int i = 0; i < 256; i++) begin
      bmem[i]   = 16'(i * 37 + 5);
      shadow[i] = 16'(i * 37 + 5);
    end
    rst_n = 1'b0; bank_en = 1'b1; ext_en = 1'b0;
    rd_setup = 4'd0; rd_dlen = 8'd0; rd_gap = 4'd0;
    wr_setup = 4'd0; wr_dlen = 8'd0; wr_gap = 4'd0;
    host_req = 1'b0; host_we = 1'b0; host_addr = '0; host_wdata = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(mem_cs_n && mem_oe_n && mem_we_n && !mem_dq_oe && !host_done,
        "R1 reset outputs", {mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe, host_done}, 5'b11100);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(mem_cs_n && !host_done, "R1 after reset", {mem_cs_n, host_done}, 2'b10);

    // directed corners: zero setup, minimum data phases
    access(1'b0, 16'h0010, 16'h0, 1'b0);
    access(1'b1, 16'h0011, 16'hBEEF, 1'b1);
    rd_setup = 4'd3; rd_gap = 4'd2;
    access(1'b0, 16'h0011, 16'h0, 1'b1);
    // R7: separate write set
    rd_setup = 4'd2; rd_dlen = 8'd5; rd_gap = 4'd3;
    wr_setup = 4'd0; wr_dlen = 8'd1; wr_gap = 4'd7;
    ext_en = 1'b1;
    access(1'b1, 16'h3012, 16'h1234, 1'b1);
    access(1'b0, 16'h3012, 16'h0, 1'b1);
    ext_en = 1'b0;
    access(1'b1, 16'h3013, 16'h4321, 1'b1);
    // longest phases
    rd_setup = 4'd15; rd_dlen = 8'd255; rd_gap = 4'd15;
    access(1'b0, 16'hFF13, 16'h0, 1'b1);
    access(1'b0, 16'h0013, 16'h0, 1'b1);

    // R8 bank disabled holds the request
    rd_setup = 4'd1; rd_dlen = 8'd2; rd_gap = 4'd0;
    bank_en = 1'b0;
    host_we = 1'b0; host_addr = 16'h0012; host_req = 1'b1;
    idle_bad = 0;
    repeat (40) begin
      @(negedge clk);
      if (!mem_cs_n || host_ack || host_done) idle_bad++;
    end
    chk(idle_bad == 0, "R8 bank off idle", idle_bad, 0);
    bank_en = 1'b1;
    access(1'b0, 16'h0012, 16'h0, 1'b0);

    // constrained random
    for (int k = 0; k < 150; k++) begin
      rd_setup = 4'($urandom % 16); rd_dlen = 8'($urandom % 24); rd_gap = 4'($urandom % 16);
      wr_setup = 4'($urandom % 16); wr_dlen = 8'($urandom % 24); wr_gap = 4'($urandom % 16);
      ext_en = 1'($urandom % 2);
      access(1'($urandom % 2), {8'($urandom), 8'($urandom % 32)}, 16'($urandom), 1'b1);
    end

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule